// File: doc/BRIEF.md
# Gated Up/Down Pulse Integration Counter

This block integrates a pulse-rate signal over time by counting pulses while a measurement window is open. The pulse train arrives with no timing relation to the system clock. It is resynchronised, and each rising edge becomes a one-cycle event. A single window input admits events only while it is high, so the count for a window is the time integral of the pulse rate over that window. The count carries the usual one-count uncertainty of an unsynchronised measurement.

Windows come in two kinds, chosen by a direction input:

- **Signal windows** add their pulses to a signed accumulator.
- **Background windows** subtract their pulses from it, which removes the background.

A background window closing completes one signal/background pair. The accumulator keeps summing across pairs until the programmed number of pairs has finished. The total is then copied to the result register, a one-cycle done strobe is raised, and the accumulator restarts for the next sequence. A synchronous clear abandons a sequence in progress. A sticky flag reports that the accumulator wrapped.

A typical use sums 10 to 20 pairs of short windows. The pulse rate is at least four times below the system clock, for example 5 MHz pulses with a 20 MHz or faster clock.

Top module: `pulse_window_integrator`

## Requirements
- R1: Each rising edge of `pulse_in` is counted exactly once, provided both its high and low phases last at least two clock periods. An edge is counted only when `win_open` is high in the detection cycle. Detection happens SYNC_STAGES clock edges after the rising edge is first sampled. Edges that occur while the window is closed have no effect on the result.
- R2: A counted edge adds +1 to the accumulator when `win_bkg` is 0 (signal window). It adds -1 when `win_bkg` is 1 (background window). `win_bkg` is held constant while a window is open.
- R3: A window closes in the first cycle in which `win_open` is sampled low after being high. The close completes a pair only when `win_bkg` was 1 in the window's last open cycle. A signal window closing never completes a pair.
- R4: When the completed pair number reaches `pairs_m1`+1, two things happen one clock cycle after the closing cycle. `result` takes the accumulator value as ACC_W-bit two's complement, including all pulses of the closing window. `done` is high for exactly that one cycle.
- R5: In the same clock cycle that `done` is raised, the accumulator and the pair counter return to zero. Each sequence's result therefore depends only on its own windows.
- R6: `result` holds its value in every cycle in which `done` is low.
- R7: `seq_clear` is synchronous. It sets the accumulator, the pair counter and `overflow` to zero. A window close sampled in the same cycle does not complete a pair.
- R8: The accumulator wraps modulo 2^ACC_W in two cases: +1 applied to the largest positive value, and -1 applied to the most negative value. A wrap sets `overflow`. `overflow` stays set across later `done` strobes until `seq_clear` or reset.
- R9: `pairs_m1` selects 1 to 2^PAIR_W pairs; the default is 1 to 32. It is held stable during a sequence.
- R10: While `rst_n` is low and after its release, `result` is 0, `done` is 0 and `overflow` is 0 until the first event changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Asynchronous pulse train to integrate |
| win_open | input | 1 | Measurement window gate, high while open |
| win_bkg | input | 1 | 0 = signal window (count up), 1 = background window (count down) |
| seq_clear | input | 1 | Synchronous clear of accumulator, pair counter and overflow flag |
| pairs_m1 | input | PAIR_W | Number of window pairs per sequence minus one |
| result | output | ACC_W | Latched signed total of the last completed sequence |
| done | output | 1 | One-cycle strobe marking a new `result` |
| overflow | output | 1 | Sticky accumulator wrap flag |

## Verification
Two results have fixed latencies.

- **Pulse to accumulator.** A pulse reaches the accumulator SYNC_STAGES+1 edges after it is first sampled. The bench therefore leaves every pulse several idle cycles before a window edge, so no count falls on a boundary.
- **Close to done.** The done strobe and the new result appear one edge after the cycle in which the closing window is sampled low. The driver records that due cycle, plus the expected value from its own pair model, in a scoreboard queue. The monitor samples at the falling clock edge and compares arrival cycle and value. Any done that arrives with nothing expected, or late, or twice, is reported as a failure.

The overflow flag is read one cycle after the clear or window that should change it.

// File: rtl/pwi_pkg.sv
package pwi_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic open;
        dir_e dir;
    } win_state_t;

endpackage

// File: rtl/pwi_pulse_sync.sv
module pwi_pulse_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic evt_o
);
    localparam int MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[SYNC_STAGES-2:0], pulse_i};
        s_d.last  = s_q.chain[MSB];
        evt_o     = s_q.chain[MSB] & ~s_q.last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o); // R1

endmodule

// File: rtl/pwi_window_track.sv
module pwi_window_track
    import pwi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_open_i,
    input  logic win_bkg_i,
    input  logic evt_i,
    output logic inc_o,
    output logic dec_o,
    output logic close_bkg_o
);
    win_state_t w_d, w_q;
    dir_e       dir_now;

    always_comb begin
        dir_now     = dir_e'(win_bkg_i);
        w_d.open    = win_open_i;
        w_d.dir     = dir_now;
        inc_o       = evt_i & win_open_i & (dir_now == DIR_UP);
        dec_o       = evt_i & win_open_i & (dir_now == DIR_DOWN);
        close_bkg_o = w_q.open & ~win_open_i & (w_q.dir == DIR_DOWN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '{open: 1'b0, dir: DIR_UP};
        else        w_q <= w_d;
    end

    AST_CLOSE_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        close_bkg_o |-> $past(win_open_i) && $past(win_bkg_i)); // R3

endmodule

// File: rtl/pwi_accum.sv
module pwi_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             restart_i,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             ovf_o
);
    localparam logic [ACC_W-1:0] MAX_POS = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MIN_NEG = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] ONE     = {{(ACC_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ovf;
    } acc_t;

    acc_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (clr_i) begin
            a_d.acc = '0;
            a_d.ovf = 1'b0;
        end else if (restart_i) begin
            a_d.acc = '0;
        end else if (inc_i) begin
            a_d.acc = a_q.acc + ONE;
            if (a_q.acc == MAX_POS) a_d.ovf = 1'b1;
        end else if (dec_i) begin
            a_d.acc = a_q.acc - ONE;
            if (a_q.acc == MIN_NEG) a_d.ovf = 1'b1;
        end
        acc_o = a_q.acc;
        ovf_o = a_q.ovf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !restart_i) |=> (acc_o == $past(acc_o))
            || (acc_o == ACC_W'($past(acc_o) + ONE))
            || (acc_o == ACC_W'($past(acc_o) - ONE))); // R2

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o); // R8

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_o == '0) && !ovf_o); // R7

endmodule

// File: rtl/pwi_seq_ctrl.sv
module pwi_seq_ctrl #(
    parameter int ACC_W  = 32,
    parameter int PAIR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              close_bkg_i,
    input  logic [PAIR_W-1:0] pairs_m1_i,
    input  logic [ACC_W-1:0]  acc_i,
    output logic              restart_o,
    output logic [ACC_W-1:0]  result_o,
    output logic              done_o
);
    typedef struct packed {
        logic [PAIR_W-1:0] pairs;
        logic [ACC_W-1:0]  result;
        logic              done;
    } seq_t;

    seq_t c_d, c_q;
    logic last_pair;

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        last_pair = close_bkg_i && (c_q.pairs == pairs_m1_i);
        restart_o = last_pair && !clr_i;
        if (clr_i) begin
            c_d.pairs = '0;
        end else if (close_bkg_i) begin
            if (last_pair) begin
                c_d.pairs  = '0;
                c_d.result = acc_i;
                c_d.done   = 1'b1;
            end else begin
                c_d.pairs = c_q.pairs + 1'b1;
            end
        end
        result_o = c_q.result;
        done_o   = c_q.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o)); // R6

    AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(close_bkg_i) && !$past(clr_i)); // R3

endmodule

// File: rtl/pulse_window_integrator.sv
module pulse_window_integrator #(
    parameter int ACC_W       = 32,
    parameter int PAIR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_in,
    input  logic              win_open,
    input  logic              win_bkg,
    input  logic              seq_clear,
    input  logic [PAIR_W-1:0] pairs_m1,
    output logic [ACC_W-1:0]  result,
    output logic              done,
    output logic              overflow
);
    logic             evt;
    logic             inc, dec, close_bkg, restart;
    logic [ACC_W-1:0] acc;

    pwi_pulse_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (pulse_in),
        .evt_o   (evt)
    );

    pwi_window_track u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_open_i  (win_open),
        .win_bkg_i   (win_bkg),
        .evt_i       (evt),
        .inc_o       (inc),
        .dec_o       (dec),
        .close_bkg_o (close_bkg)
    );

    pwi_accum #(.ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (seq_clear),
        .restart_i (restart),
        .inc_i     (inc),
        .dec_i     (dec),
        .acc_o     (acc),
        .ovf_o     (overflow)
    );

    pwi_seq_ctrl #(.ACC_W(ACC_W), .PAIR_W(PAIR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (seq_clear),
        .close_bkg_i (close_bkg),
        .pairs_m1_i  (pairs_m1),
        .acc_i       (acc),
        .restart_o   (restart),
        .result_o    (result),
        .done_o      (done)
    );

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc == '0) || $past(seq_clear)); // R5

endmodule

// File: tb/pulse_window_integrator_bench.sv
`timescale 1ns/1ps
module pulse_window_integrator_bench;
    localparam int ACC_W  = 8;
    localparam int PAIR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pulse_in = 1'b0;
    logic              win_open = 1'b0;
    logic              win_bkg = 1'b0;
    logic              seq_clear = 1'b0;
    logic [PAIR_W-1:0] pairs_m1 = '0;
    logic [ACC_W-1:0]  result;
    logic              done;
    logic              overflow;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        logic signed [ACC_W-1:0] val;
        int                      due;
    } exp_t;
    exp_t sb[$];

    logic signed [ACC_W-1:0] acc_m = '0;
    int  pair_m = 0;
    bit  ovf_m = 1'b0;

    pulse_window_integrator #(.ACC_W(ACC_W), .PAIR_W(PAIR_W)) u_pulse_window_integrator (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .win_open(win_open),
        .win_bkg(win_bkg), .seq_clear(seq_clear), .pairs_m1(pairs_m1),
        .result(result), .done(done), .overflow(overflow)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic one_pulse();
        pulse_in = 1'b1; tick(2);
        pulse_in = 1'b0; tick(2);
    endtask

    task automatic model_step(input bit bkg);
        if (!bkg) begin
            if (acc_m == 8'sd127) ovf_m = 1'b1;
            acc_m = acc_m + 8'sd1;
        end else begin
            if (acc_m == -8'sd128) ovf_m = 1'b1;
            acc_m = acc_m - 8'sd1;
        end
    endtask

    // R1 R2 R3: open window, n pulses well inside it, close it
    task automatic run_window(input bit bkg, input int n);
        win_bkg = bkg; tick(1);
        win_open = 1'b1; tick(2);
        for (int i = 0; i < n; i++) begin
            one_pulse();
            model_step(bkg);
        end
        tick(3);
        win_open = 1'b0;
        if (bkg) begin
            pair_m++;
            if (pair_m == int'(pairs_m1) + 1) begin
                sb.push_back('{acc_m, cyc + 1});   // R4: done one edge after close cycle
                acc_m = '0;                        // R5
                pair_m = 0;
            end
        end
        tick(1);
        win_bkg = 1'b0;
        tick(2);
    endtask

    task automatic do_clear();
        seq_clear = 1'b1; tick(1);
        seq_clear = 1'b0;
        acc_m = '0; pair_m = 0; ovf_m = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R4 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(cyc == e.due, "R4 done cycle", cyc, e.due);
                chk($signed(result) == e.val, "R4 R2 result", int'($signed(result)), int'(e.val));
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        chk(result == '0, "R10 result in reset", int'(result), 0);
        chk(done == 1'b0, "R10 done in reset", int'(done), 0);
        rst_n = 1'b1;
        tick(1);
        chk(result == '0 && !done && !overflow, "R10 after reset", int'(overflow), 0);

        // single pair, positive
        pairs_m1 = 5'd0;
        run_window(1'b0, 5);
        run_window(1'b1, 2);

        // three pairs with mixed sums (R5 restart from previous)
        pairs_m1 = 5'd2;
        run_window(1'b0, 7); run_window(1'b1, 2);
        run_window(1'b0, 4); run_window(1'b1, 1);
        run_window(1'b0, 3); run_window(1'b1, 6);

        // negative result
        pairs_m1 = 5'd0;
        run_window(1'b0, 1);
        run_window(1'b1, 4);

        // R1: pulses with window closed are ignored
        win_bkg = 1'b0; one_pulse(); one_pulse();
        win_bkg = 1'b1; one_pulse();
        win_bkg = 1'b0; tick(4);
        run_window(1'b0, 2);
        run_window(1'b1, 0);

        // R3: signal closes do not complete pairs
        pairs_m1 = 5'd1;
        run_window(1'b0, 2);
        run_window(1'b0, 1);
        run_window(1'b1, 1);
        run_window(1'b0, 3);
        run_window(1'b1, 0);

        // R7: clear mid-sequence
        run_window(1'b0, 3);
        run_window(1'b1, 1);
        do_clear();
        run_window(1'b0, 2); run_window(1'b1, 0);
        run_window(1'b0, 4); run_window(1'b1, 1);

        // R9: maximum pair count (32)
        pairs_m1 = 5'd31;
        for (int p = 0; p < 32; p++) begin
            run_window(1'b0, 1);
            run_window(1'b1, 0);
        end

        // R8: overflow on wrap, sticky across done, cleared by seq_clear
        pairs_m1 = 5'd0;
        chk(overflow == 1'b0, "R8 no overflow yet", int'(overflow), 0);
        run_window(1'b0, 128);
        chk(overflow == ovf_m, "R8 overflow set on wrap", int'(overflow), int'(ovf_m));
        run_window(1'b1, 0);
        run_window(1'b0, 1);
        run_window(1'b1, 0);
        chk(overflow == 1'b1, "R8 overflow sticky across done", int'(overflow), 1);
        do_clear();
        chk(overflow == 1'b0, "R7 R8 overflow cleared", int'(overflow), 0);
        // R8 down-wrap
        run_window(1'b1, 129);
        chk(overflow == 1'b1, "R8 overflow on down wrap", int'(overflow), 1);

        tick(6);
        chk(sb.size() == 0, "R4 all expected results seen", sb.size(), 0);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule